// File: doc/BRIEF.md
# Fuse Bit Program-and-Verify Controller

This controller burns a run of one-time-programmable fuse bits. A request carries a starting bit address, a signed bit count and a vector of data bits. Data bits of 0 are passed over, because an unburned fuse already reads 0. Each data bit of 1 first gets a fixed number of unchecked program pulses. After that, each further pulse is followed by a read-back of the target bit. The controller moves on as soon as that bit reads 1. If the bit is still 0 after the last allowed attempt, the whole request stops with a failure, and the controller reports the address of the bit that would not burn.

Pulses go to an external pulse sequencer through a single-cycle request and a done strobe. The sequencer returns an 8-bit read-back byte with each done strobe. The controller picks the target bit out of that byte using the low three bits of the bit address. Before the first bit of a request, the controller drives an active-low reset to the fuse macro for a minimum width and then waits a settle time.

The state machine has these states: `S_IDLE`, `S_RST_LO`, `S_RST_HOLD`, `S_SCAN`, `S_BLIND_REQ`, `S_BLIND_WAIT`, `S_GAP`, `S_VFY_REQ`, `S_VFY_WAIT` and `S_FINISH`.

Its transitions are:
- From `S_IDLE` on start: a valid size goes to `S_RST_LO`, an invalid size goes to `S_FINISH`.
- `S_RST_LO` goes to `S_RST_HOLD` when its timer expires.
- `S_RST_HOLD` goes to `S_SCAN` when its timer expires.
- From `S_SCAN`:
  - no bits remain: go to `S_FINISH`;
  - the current bit is 0: stay in `S_SCAN` and advance;
  - the current bit is 1: go to `S_BLIND_REQ`, or to `S_GAP` when no unchecked pulses are configured.
- `S_BLIND_REQ` goes to `S_BLIND_WAIT`.
- From `S_BLIND_WAIT` on done: go back to `S_BLIND_REQ`, or to `S_GAP` after the last unchecked pulse.
- `S_GAP` goes to `S_VFY_REQ` when its timer expires.
- `S_VFY_REQ` goes to `S_VFY_WAIT`.
- From `S_VFY_WAIT` on done:
  - the bit reads 1: go to `S_SCAN`;
  - the bit reads 0 and tries remain: go to `S_GAP`;
  - the bit reads 0 and no tries remain: go to `S_FINISH`.
- `S_FINISH` goes to `S_IDLE`.

Top module: `fuse_prog_retry`

## Requirements
- R1: A start with `bit_count` ≤ 0, or above MAX_BITS (16), finishes with `status` = 2 (bad size). It issues no pulse and gives no fuse reset.
- R2: Before the first pulse of an accepted request, `dev_rst_n` is low for at least RST_LOW_CYC (2) cycles. It then stays high for at least SETTLE_CYC (100) cycles before the first `pulse_req`. Each accepted request gives exactly one such reset.
- R3: No pulse is ever requested for an address whose data bit is 0.
- R4: Each data bit of 1 receives BLIND_PULSES (3) pulses that are not checked.
- R5: After each checked pulse, the controller tests bit (`pulse_ofs` mod 8) of `rd_byte`, sampled with `pulse_done`. The first 1 ends pulsing for that bit. A bit whose fuse reads 1 after n total pulses therefore takes max(4, n) pulses.
- R6: At least GAP_CYC (10) cycles pass between a `pulse_done` and the `pulse_req` of a checked pulse.
- R7: If the bit still reads 0 after VERIFY_TRIES (13) checked pulses, the request ends with `status` = 3 and `fail_ofs` equal to that bit's address. No pulse follows for later bits.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle. A `start` while busy is ignored.
- R9: `pulse_req` lasts one cycle. No new request is issued until `pulse_done` has been returned.
- R10: A request whose 1 bits all verify ends with `status` = 1. This includes a request with no 1 bits, which issues no pulse.
- R11: `pulse_ofs` equals `base_ofs` plus the index of the data bit being burned. Data bit i is burned at address `base_ofs + i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| base_ofs | input | OFS_W | Bit address of data bit 0 |
| bit_count | input | CNT_W | Signed number of bits to handle |
| bit_data | input | MAX_BITS | Data bits; bit i is for address base_ofs+i |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| status | output | 2 | 0 none, 1 ok, 2 bad size, 3 failed to burn |
| fail_ofs | output | OFS_W | Address of the bit that failed |
| dev_rst_n | output | 1 | Active-low reset to the fuse macro |
| pulse_req | output | 1 | One-cycle program pulse request |
| pulse_ofs | output | OFS_W | Bit address for the pulse |
| pulse_done | input | 1 | Pulse and read-back complete |
| rd_byte | input | 8 | Read-back byte, valid with pulse_done |

## Verification
The following properties are checked on every cycle:
- the handshake rules: `pulse_req` lasts one cycle, and only one request is outstanding;
- `pulse_req` never occurs while the fuse reset is low or while the controller is idle;
- the width of the fuse reset;
- `busy` covering `done`, and a result code being present at `done`.

Some behaviour can only be shown by the bench's scenarios, against its fuse model that burns after a set number of pulses:
- the pulse count per bit, which depends on when each fuse burns;
- the skipping of 0 bits;
- the choice of lane within the read-back byte;
- the abort address on failure;
- the gap before checked pulses;
- ignoring a second start.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RST_LO, S_RST_HOLD, S_SCAN, S_BLIND_REQ, S_BLIND_WAIT,
        S_GAP, S_VFY_REQ, S_VFY_WAIT, S_FINISH
    } state_t;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_OK      = 2'd1,
        RES_BADSIZE = 2'd2,
        RES_FAIL    = 2'd3
    } result_t;
endpackage

// File: rtl/fuse_prog_timer.sv
// Down-counter: load has priority, expired while count is zero.
module fuse_prog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_prog_lane_pick.sv
// Selects the addressed bit out of a read-back word.
module fuse_prog_lane_pick #(
    parameter int LANE_W = 8,
    localparam int SEL_W = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_out
);
    assign bit_out = word[sel];
endmodule

// File: rtl/fuse_prog_retry.sv
module fuse_prog_retry
    import fuse_prog_pkg::*;
#(
    parameter int MAX_BITS     = 16,
    parameter int OFS_W        = 10,
    parameter int CNT_W        = 8,
    parameter int BLIND_PULSES = 3,
    parameter int VERIFY_TRIES = 13,
    parameter int RST_LOW_CYC  = 2,
    parameter int SETTLE_CYC   = 100,
    parameter int GAP_CYC      = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [OFS_W-1:0]        base_ofs,
    input  logic signed [CNT_W-1:0] bit_count,
    input  logic [MAX_BITS-1:0]     bit_data,
    output logic                    busy,
    output logic                    done,
    output logic [1:0]              status,
    output logic [OFS_W-1:0]        fail_ofs,
    output logic                    dev_rst_n,
    output logic                    pulse_req,
    output logic [OFS_W-1:0]        pulse_ofs,
    input  logic                    pulse_done,
    input  logic [7:0]              rd_byte
);
    localparam int IDX_W  = $clog2(MAX_BITS + 1);
    localparam int BLD_W  = $clog2(BLIND_PULSES + 2);
    localparam int TRY_W  = $clog2(VERIFY_TRIES + 1);
    localparam int TMAX_A = (RST_LOW_CYC > SETTLE_CYC) ? RST_LOW_CYC : SETTLE_CYC;
    localparam int TMAX   = (TMAX_A > GAP_CYC) ? TMAX_A : GAP_CYC;
    localparam int TMR_W  = $clog2(TMAX + 1);

    state_t              state, nxt;
    result_t             result_q;
    logic [OFS_W-1:0]    cur_ofs, fail_ofs_q;
    logic [IDX_W-1:0]    rem_q;
    logic [MAX_BITS-1:0] data_sh;
    logic [BLD_W-1:0]    blind_cnt;
    logic [TRY_W-1:0]    try_cnt;
    logic                tmr_load, tmr_exp, bit_ok, size_ok;
    logic [TMR_W-1:0]    tmr_val;
    int                  cnt_i;

    assign cnt_i   = int'(bit_count);
    assign size_ok = (cnt_i > 0) && (cnt_i <= MAX_BITS);

    fuse_prog_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    fuse_prog_lane_pick #(.LANE_W(8)) u_pick (
        .word(rd_byte), .sel(cur_ofs[2:0]), .bit_out(bit_ok)
    );

    // next state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: if (start) begin
                if (size_ok) begin
                    nxt = S_RST_LO; tmr_load = 1'b1; tmr_val = TMR_W'(RST_LOW_CYC);
                end else nxt = S_FINISH;
            end
            S_RST_LO: if (tmr_exp) begin
                nxt = S_RST_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
            end
            S_RST_HOLD: if (tmr_exp) nxt = S_SCAN;
            S_SCAN: begin
                if (rem_q == '0) nxt = S_FINISH;
                else if (data_sh[0]) begin
                    if (BLIND_PULSES == 0) begin
                        nxt = S_GAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC);
                    end else nxt = S_BLIND_REQ;
                end
            end
            S_BLIND_REQ: nxt = S_BLIND_WAIT;
            S_BLIND_WAIT: if (pulse_done) begin
                if (blind_cnt == BLD_W'(BLIND_PULSES - 1)) begin
                    nxt = S_GAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC);
                end else nxt = S_BLIND_REQ;
            end
            S_GAP: if (tmr_exp) nxt = S_VFY_REQ;
            S_VFY_REQ: nxt = S_VFY_WAIT;
            S_VFY_WAIT: if (pulse_done) begin
                if (bit_ok) nxt = S_SCAN;
                else if (try_cnt == TRY_W'(VERIFY_TRIES - 1)) nxt = S_FINISH;
                else begin
                    nxt = S_GAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC);
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            result_q   <= RES_NONE;
            cur_ofs    <= '0;
            fail_ofs_q <= '0;
            rem_q      <= '0;
            data_sh    <= '0;
            blind_cnt  <= '0;
            try_cnt    <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (start) begin
                    cur_ofs    <= base_ofs;
                    data_sh    <= bit_data;
                    fail_ofs_q <= '0;
                    rem_q      <= size_ok ? IDX_W'(cnt_i) : '0;
                    result_q   <= size_ok ? RES_NONE : RES_BADSIZE;
                end
                S_SCAN: begin
                    blind_cnt <= '0;
                    try_cnt   <= '0;
                    if (rem_q == '0) result_q <= RES_OK;
                    else if (!data_sh[0]) begin
                        rem_q   <= rem_q - IDX_W'(1);
                        cur_ofs <= cur_ofs + OFS_W'(1);
                        data_sh <= data_sh >> 1;
                    end
                end
                S_BLIND_WAIT: if (pulse_done) blind_cnt <= blind_cnt + BLD_W'(1);
                S_VFY_WAIT: if (pulse_done) begin
                    if (bit_ok) begin
                        rem_q   <= rem_q - IDX_W'(1);
                        cur_ofs <= cur_ofs + OFS_W'(1);
                        data_sh <= data_sh >> 1;
                    end else if (try_cnt == TRY_W'(VERIFY_TRIES - 1)) begin
                        result_q   <= RES_FAIL;
                        fail_ofs_q <= cur_ofs;
                    end else try_cnt <= try_cnt + TRY_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        dev_rst_n = (state != S_RST_LO);
        pulse_req = (state == S_BLIND_REQ) || (state == S_VFY_REQ);
        pulse_ofs = cur_ofs;
        status    = result_q;
        fail_ofs  = fail_ofs_q;
    end
endmodule

// File: rtl/fuse_prog_retry_chk.sv
module fuse_prog_retry_chk #(
    parameter int RST_LOW_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       dev_rst_n,
    input logic       pulse_req,
    input logic       pulse_done
);
    logic        pend;
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            low_cnt <= '0;
        end else begin
            if (pulse_req)       pend <= 1'b1;
            else if (pulse_done) pend <= 1'b0;
            if (dev_rst_n)                low_cnt <= '0;
            else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
        end
    end

    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |=> !pulse_req);
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |-> !pend);
    assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse_req && dev_rst_n));
    assert_no_pulse_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |-> dev_rst_n);
    assert_reset_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n) |-> (low_cnt >= 16'(RST_LOW_CYC)));
    assert_result_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd0));
endmodule

bind fuse_prog_retry fuse_prog_retry_chk #(.RST_LOW_CYC(RST_LOW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
    .dev_rst_n(dev_rst_n), .pulse_req(pulse_req), .pulse_done(pulse_done)
);

// File: tb/test_fuse_prog_retry.sv
module test_fuse_prog_retry;
    localparam int MAX_BITS = 16, OFS_W = 10, CNT_W = 8;
    localparam int BLIND = 3, TRIES = 13, RST_LOW = 2, SETTLE = 100, GAP = 10;
    localparam int LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [OFS_W-1:0] base_ofs = '0;
    logic signed [CNT_W-1:0] bit_count = '0;
    logic [MAX_BITS-1:0] bit_data = '0;
    logic busy, done, dev_rst_n, pulse_req, pulse_done = 1'b0;
    logic [1:0] status;
    logic [OFS_W-1:0] fail_ofs, pulse_ofs;
    logic [7:0] rd_byte = 8'h00;

    always #5 clk = ~clk;

    fuse_prog_retry i_fuse_prog_retry (
        .clk(clk), .rst_n(rst_n), .start(start), .base_ofs(base_ofs),
        .bit_count(bit_count), .bit_data(bit_data), .busy(busy), .done(done),
        .status(status), .fail_ofs(fail_ofs), .dev_rst_n(dev_rst_n),
        .pulse_req(pulse_req), .pulse_ofs(pulse_ofs), .pulse_done(pulse_done),
        .rd_byte(rd_byte)
    );

    int checks = 0, fails = 0;
    typedef struct { int st; int fofs; int pulses; int resets; } exp_t;
    exp_t q[$];
    int need [0:1023];
    int pcnt [0:1023];
    int op_base = 0;
    logic [MAX_BITS-1:0] op_data = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sequencer + fuse model first, then monitor, in one process
    int lat = 0, lofs = 0;
    int op_pulses = 0, op_resets = 0, low_run = 0, hold = 0, since_done = 1000;
    int bit_pulses = 0, last_ofs = -1;
    bit await_first = 0, prev_rst = 1;
    always @(negedge clk) if (rst_n) begin
        // monitor
        if (!dev_rst_n && prev_rst) op_resets++;
        if (!dev_rst_n) low_run++;
        else if (!prev_rst) begin
            chk(low_run >= RST_LOW, "R2 reset width", low_run, RST_LOW);
            low_run = 0; hold = 0; await_first = 1;
        end
        hold++;
        if (pulse_req) begin
            int idx;
            op_pulses++;
            if (await_first) begin
                chk(hold - 1 >= SETTLE, "R2 settle before first pulse", hold - 1, SETTLE);
                await_first = 0;
            end
            idx = int'(pulse_ofs) - op_base;
            chk(idx >= 0 && idx < MAX_BITS && op_data[idx & 15] == 1'b1,
                "R3/R11 pulse only on 1 bits", idx, 1);
            if (int'(pulse_ofs) != last_ofs) bit_pulses = 0;
            bit_pulses++;
            last_ofs = int'(pulse_ofs);
            if (bit_pulses > BLIND)
                chk(since_done >= GAP, "R6 gap before checked pulse", since_done, GAP);
        end
        if (pulse_done) since_done = 0; else since_done++;
        if (done) begin
            exp_t e;
            if (q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
            else begin
                e = q.pop_front();
                chk(int'(status) == e.st, "R1/R7/R10 status", int'(status), e.st);
                if (e.st == 3) chk(int'(fail_ofs) == e.fofs, "R7 fail_ofs", int'(fail_ofs), e.fofs);
                chk(op_pulses == e.pulses, "R4/R5 pulse count", op_pulses, e.pulses);
                chk(op_resets == e.resets, "R1/R2 reset count", op_resets, e.resets);
                chk(busy == 1'b1, "R8 busy at done", int'(busy), 1);
            end
            op_pulses = 0; op_resets = 0; last_ofs = -1;
        end
        prev_rst = dev_rst_n;
        // sequencer model
        pulse_done = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                pcnt[lofs]++;
                pulse_done = 1'b1;
                rd_byte = (need[lofs] != 0 && pcnt[lofs] >= need[lofs]) ? 8'hFF
                          : ~(8'h01 << (lofs % 8));
            end
        end
        if (pulse_req) begin lat = LAT; lofs = int'(pulse_ofs); end
    end

    task automatic run_op(input int base, input int cnt, input logic [MAX_BITS-1:0] data,
                          input bit poke);
        exp_t e;
        e.st = 1; e.fofs = 0; e.pulses = 0; e.resets = 1;
        if (cnt <= 0 || cnt > MAX_BITS) begin e.st = 2; e.resets = 0; end
        else for (int i = 0; i < cnt; i++) begin
            if (data[i]) begin
                int n = need[base + i];
                if (n != 0 && n <= BLIND + TRIES) e.pulses += (n < BLIND + 1) ? BLIND + 1 : n;
                else begin
                    e.pulses += BLIND + TRIES; e.st = 3; e.fofs = base + i;
                    break;
                end
            end
        end
        for (int a = 0; a < 1024; a++) pcnt[a] = 0;
        q.push_back(e);
        @(negedge clk);
        op_base = base; op_data = data;
        base_ofs = OFS_W'(base); bit_count = CNT_W'(cnt); bit_data = data;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            base_ofs = 10'd900; bit_count = 8'sd16; bit_data = 16'hFFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R8 one result per accepted start", q.size(), 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            summary();
        end
    end

    initial begin
        for (int a = 0; a < 1024; a++) need[a] = 1;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R8 reset busy", int'(busy), 0);
        chk(done == 0, "R8 reset done", int'(done), 0);
        chk(pulse_req == 0, "R9 reset pulse_req", int'(pulse_req), 0);
        chk(dev_rst_n == 1, "R2 reset dev_rst_n", int'(dev_rst_n), 1);
        chk(status == 0, "R10 reset status", int'(status), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: bad sizes
        run_op(3, 0, 16'hFFFF, 0);
        run_op(3, -3, 16'hFFFF, 0);
        run_op(3, MAX_BITS + 1, 16'hFFFF, 0);
        // R10: no ones
        run_op(40, 8, 16'h0000, 0);
        // R3 R4 R11: skip pattern, quick burns
        run_op(5, 6, 16'b101101, 0);
        // R5: varied burn points, odd base so lanes vary
        need[13] = 4; need[15] = 9; need[16] = 16; need[18] = 2;
        run_op(13, 6, 16'b010111, 0);
        // R7: second one bit never burns within budget
        need[100] = 5; need[102] = 17; need[103] = 1;
        run_op(100, 4, 16'b1101, 0);
        // R7: fuse that never burns, first bit
        need[200] = 0;
        run_op(200, 3, 16'b111, 0);
        // R8: start while busy ignored
        need[300] = 10; need[301] = 7;
        run_op(300, 2, 16'b11, 1);
        // full width
        for (int a = 500; a < 516; a++) need[a] = 6;
        run_op(500, MAX_BITS, 16'hFFFF, 0);
        summary();
    end
endmodule